// File: doc/BRIEF.md
# Three-Channel Doorbell Mailbox

This block is an APB-attached mailbox that passes event flags between a local processor and a remote one. It has three independent channels, and each channel holds a 32-bit status word. Software never writes a status word directly. A write to the channel's set register ORs the written ones into the word. A write to its clear register removes the bits written as one. The word is read back through a read-only status register. Each channel drives one interrupt line, which goes high whenever any bit of its word is set.

The block serves two uses. In message use, the sender raises bits and then polls the status word, and the receiver clears the bits once it has consumed the message. In doorbell use, each of the 32 bits is an event of its own. Hardware never clears a bit by itself and never acknowledges delivery. Channel 0 is the low-priority non-secure channel and channel 1 is the high-priority non-secure one. Channel 2 accepts only secure accesses, judged by the protection bit `pprot[1]`.

The register window spans 4 KB. Channel bases are 0x000, 0x020 and 0x200. Within a channel, the status register sits at +0x00, the set register at +0x08 and the clear register at +0x10.

Top module: `dbell_mbox`

## Requirements
- R1: While `presetn` is low, all three status words are zero and `irq_o` is 3'b000. This also applies to a reset taken in the middle of operation.
- R2: A write to a channel's set register (base+0x08) ORs `pwdata` into that channel's word and leaves every other bit unchanged.
- R3: A write to a channel's clear register (base+0x10) clears each bit where `pwdata` is 1 and keeps the other bits.
- R4: A read of the status register (base+0x00) returns the word. Writes to the status register are ignored. Reads of the set and clear registers return zero.
- R5: `irq_o[i]` is the OR of channel i's word, registered. It rises one pclk cycle after the write edge that makes the word non-zero, and falls one cycle after the write edge that makes it zero.
- R6: An access to one channel never changes the word or the interrupt of another channel.
- R7: An access to any channel-2 register with `pprot[1]`=1 completes with `pslverr`=1, its write is ignored and its read returns zero. The same access with `pprot[1]`=0 completes with `pslverr`=0 and takes effect.
- R8: Channels 0 and 1 accept accesses with `pprot[1]`=1, with `pslverr`=0.
- R9: Addresses that map to no register read as zero, ignore writes and return `pslverr`=0.
- R10: `pready` is always 1, so every transfer has zero wait states.
- R11: A word holds its value until a set or clear write or a reset changes it. Idle cycles leave it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | APB clock |
| presetn | input | 1 | Active-low asynchronous reset |
| psel | input | 1 | APB select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | 12 | Byte address within the 4 KB window |
| pwdata | input | 32 | Write data (bit mask for set/clear) |
| pprot | input | 3 | Protection; bit 1 = non-secure |
| prdata | output | 32 | Read data, valid in the access phase |
| pready | output | 1 | Tied high |
| pslverr | output | 1 | Error for a non-secure access to channel 2 |
| irq_o | output | 3 | Per-channel interrupt lines |

## Verification
A write takes effect on the pclk edge that ends its access phase. `prdata`, `pready` and `pslverr` are combinational, so each is valid during the access phase of its own transfer. An interrupt moves exactly one edge after the status word changes. The bench samples the bus outputs one nanosecond into the access phase. It checks each interrupt twice: on the falling edge just after the write, where the old value must still show, and one falling edge later, where the new value must show. This pins the latency to exactly one cycle.

// File: rtl/dbell_mbox_pkg.sv
package dbell_mbox_pkg;
   // register offsets inside one channel
   localparam int OFS_STAT  = 'h00;
   localparam int OFS_SET   = 'h08;
   localparam int OFS_CLR   = 'h10;
   // channel layout: non-secure channels packed from 0, secure ones from SEC_BASE
   localparam int CH_STRIDE = 'h20;
   localparam int SEC_BASE  = 'h200;

   function automatic int chan_base(input int idx, input int n_open);
      if (idx < n_open) return idx * CH_STRIDE;
      return SEC_BASE + (idx - n_open) * CH_STRIDE;
   endfunction
endpackage

// File: rtl/dbell_decode.sv
module dbell_decode #(
   parameter int                ADDR_W   = 12,
   parameter int                N_CHAN   = 3,
   parameter int                N_OPEN   = 2,
   parameter logic [N_CHAN-1:0] SEC_MASK = 3'b100
) (
   input  logic [ADDR_W-1:2]  waddr,
   input  logic               nonsec,
   output logic [N_CHAN-1:0]  hit_stat,
   output logic [N_CHAN-1:0]  hit_set,
   output logic [N_CHAN-1:0]  hit_clr,
   output logic [N_CHAN-1:0]  deny
);
   import dbell_mbox_pkg::*;

   for (genvar i = 0; i < N_CHAN; i++) begin : g_ch
      localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(chan_base(i, N_OPEN) + OFS_STAT);
      localparam logic [ADDR_W-1:0] A_SET  = ADDR_W'(chan_base(i, N_OPEN) + OFS_SET);
      localparam logic [ADDR_W-1:0] A_CLR  = ADDR_W'(chan_base(i, N_OPEN) + OFS_CLR);

      assign hit_stat[i] = (waddr == A_STAT[ADDR_W-1:2]);
      assign hit_set[i]  = (waddr == A_SET[ADDR_W-1:2]);
      assign hit_clr[i]  = (waddr == A_CLR[ADDR_W-1:2]);

      if (SEC_MASK[i]) begin : g_secure
         assign deny[i] = nonsec & (hit_stat[i] | hit_set[i] | hit_clr[i]);
      end else begin : g_open
         assign deny[i] = 1'b0;
      end
   end
endmodule

// File: rtl/dbell_chan.sv
module dbell_chan #(
   parameter int DATA_W  = 32,
   parameter bit IRQ_REG = 1'b1
) (
   input  logic              pclk,
   input  logic              presetn,
   input  logic              set_en,
   input  logic              clr_en,
   input  logic [DATA_W-1:0] mask,
   output logic [DATA_W-1:0] word_o,
   output logic              irq_o
);
   logic [DATA_W-1:0] word_q;
   logic [DATA_W-1:0] set_m, clr_m;

   assign set_m = set_en ? mask : '0;
   assign clr_m = clr_en ? mask : '0;

   // clear dominates a simultaneous set of the same bit
   always_ff @(posedge pclk or negedge presetn) begin
      if (!presetn)               word_q <= '0;
      else if (set_en || clr_en)  word_q <= (word_q | set_m) & ~clr_m;
   end

   assign word_o = word_q;

   if (IRQ_REG) begin : g_irq_ff
      logic irq_q;
      always_ff @(posedge pclk or negedge presetn) begin
         if (!presetn) irq_q <= 1'b0;
         else          irq_q <= |word_q;
      end
      assign irq_o = irq_q;
   end else begin : g_irq_comb
      assign irq_o = |word_q;
   end
endmodule

// File: rtl/dbell_rdmux.sv
module dbell_rdmux #(
   parameter int DATA_W = 32,
   parameter int N_CHAN = 3
) (
   input  logic                     rd_en,
   input  logic [N_CHAN-1:0]        sel,
   input  logic [N_CHAN*DATA_W-1:0] words,
   output logic [DATA_W-1:0]        rdata
);
   always_comb begin
      rdata = '0;
      for (int i = 0; i < N_CHAN; i++) begin
         if (rd_en && sel[i]) rdata = rdata | words[i*DATA_W +: DATA_W];
      end
   end
endmodule

// File: rtl/dbell_mbox.sv
module dbell_mbox #(
   parameter int                DATA_W   = 32,
   parameter int                ADDR_W   = 12,
   parameter int                N_CHAN   = 3,
   parameter logic [N_CHAN-1:0] SEC_MASK = 3'b100,
   parameter bit                IRQ_REG  = 1'b1
) (
   input  logic              pclk,
   input  logic              presetn,
   input  logic              psel,
   input  logic              penable,
   input  logic              pwrite,
   input  logic [ADDR_W-1:0] paddr,
   input  logic [DATA_W-1:0] pwdata,
   input  logic [2:0]        pprot,
   output logic [DATA_W-1:0] prdata,
   output logic              pready,
   output logic              pslverr,
   output logic [N_CHAN-1:0] irq_o
);
   localparam int N_SEC  = $countones(SEC_MASK);
   localparam int N_OPEN = N_CHAN - N_SEC;

   if (ADDR_W < 10 || ADDR_W > 16) begin : g_bad_addr
      $error("dbell_mbox: ADDR_W must lie in 10..16");
   end
   if (N_CHAN < 1 || N_CHAN > 8) begin : g_bad_chan
      $error("dbell_mbox: N_CHAN must lie in 1..8");
   end
   if (DATA_W < 1 || DATA_W > 32) begin : g_bad_data
      $error("dbell_mbox: DATA_W must lie in 1..32");
   end

   logic                     acc, wr, rd, nonsec;
   logic [N_CHAN-1:0]        hit_stat, hit_set, hit_clr, deny;
   logic [N_CHAN*DATA_W-1:0] word_flat;
   logic                     unused_bits;

   assign acc    = psel & penable;
   assign wr     = acc & pwrite;
   assign rd     = acc & ~pwrite;
   assign nonsec = pprot[1];
   assign unused_bits = ^{pprot[2], pprot[0], paddr[1:0]};

   dbell_decode #(
      .ADDR_W(ADDR_W), .N_CHAN(N_CHAN), .N_OPEN(N_OPEN), .SEC_MASK(SEC_MASK)
   ) u_dec (
      .waddr    (paddr[ADDR_W-1:2]),
      .nonsec   (nonsec),
      .hit_stat (hit_stat),
      .hit_set  (hit_set),
      .hit_clr  (hit_clr),
      .deny     (deny)
   );

   for (genvar i = 0; i < N_CHAN; i++) begin : g_chan
      dbell_chan #(.DATA_W(DATA_W), .IRQ_REG(IRQ_REG)) u_ch (
         .pclk    (pclk),
         .presetn (presetn),
         .set_en  (wr & hit_set[i] & ~deny[i]),
         .clr_en  (wr & hit_clr[i] & ~deny[i]),
         .mask    (pwdata),
         .word_o  (word_flat[i*DATA_W +: DATA_W]),
         .irq_o   (irq_o[i])
      );
   end

   dbell_rdmux #(.DATA_W(DATA_W), .N_CHAN(N_CHAN)) u_rd (
      .rd_en (rd),
      .sel   (hit_stat & ~deny),
      .words (word_flat),
      .rdata (prdata)
   );

   assign pready  = 1'b1;
   assign pslverr = acc & (|deny);
endmodule

// File: rtl/dbell_mbox_chk.sv
module dbell_mbox_chk #(
   parameter int                DATA_W   = 32,
   parameter int                ADDR_W   = 12,
   parameter int                N_CHAN   = 3,
   parameter logic [N_CHAN-1:0] SEC_MASK = 3'b100
) (
   input logic                     pclk,
   input logic                     presetn,
   input logic                     psel,
   input logic                     penable,
   input logic                     pwrite,
   input logic [ADDR_W-1:0]        paddr,
   input logic [DATA_W-1:0]        pwdata,
   input logic                     ns_i,
   input logic [DATA_W-1:0]        prdata,
   input logic                     pready,
   input logic                     pslverr,
   input logic [N_CHAN-1:0]        irq_o,
   input logic [N_CHAN*DATA_W-1:0] stat_i
);
   import dbell_mbox_pkg::*;
   localparam int N_OPEN = N_CHAN - $countones(SEC_MASK);

   logic acc;
   assign acc = psel & penable;

   AST_READY_HIGH: assert property (@(posedge pclk) disable iff (!presetn)
      pready == 1'b1); // R10

   AST_IDLE_HOLDS: assert property (@(posedge pclk) disable iff (!presetn)
      !(acc && pwrite) |=> $stable(stat_i)); // R11

   AST_UNMAPPED_ZERO: assert property (@(posedge pclk) disable iff (!presetn)
      (acc && !pwrite && paddr >= ADDR_W'('h400)) |-> (prdata == '0 && !pslverr)); // R9

   for (genvar i = 0; i < N_CHAN; i++) begin : g_ch
      localparam logic [ADDR_W-1:0] A_SET = ADDR_W'(chan_base(i, N_OPEN) + OFS_SET);
      localparam logic [ADDR_W-1:0] A_BASE = ADDR_W'(chan_base(i, N_OPEN));

      AST_IRQ_AFTER_SET: assert property (@(posedge pclk) disable iff (!presetn)
         (acc && pwrite && paddr == A_SET && pwdata != '0 && !(SEC_MASK[i] && ns_i))
         |=> ##1 irq_o[i]); // R5

      if (SEC_MASK[i]) begin : g_sec
         AST_NS_ERROR: assert property (@(posedge pclk) disable iff (!presetn)
            (acc && ns_i && paddr[ADDR_W-1:5] == A_BASE[ADDR_W-1:5]
             && paddr[4:0] inside {5'h00, 5'h08, 5'h10}) |-> pslverr); // R7
         AST_NS_NO_WRITE: assert property (@(posedge pclk) disable iff (!presetn)
            (acc && pwrite && ns_i && paddr[ADDR_W-1:5] == A_BASE[ADDR_W-1:5])
            |=> $stable(stat_i[i*DATA_W +: DATA_W])); // R7
      end
   end
endmodule

bind dbell_mbox dbell_mbox_chk #(
   .DATA_W(DATA_W), .ADDR_W(ADDR_W), .N_CHAN(N_CHAN), .SEC_MASK(SEC_MASK)
) u_chk (
   .pclk(pclk), .presetn(presetn), .psel(psel), .penable(penable), .pwrite(pwrite),
   .paddr(paddr), .pwdata(pwdata), .ns_i(pprot[1]), .prdata(prdata), .pready(pready),
   .pslverr(pslverr), .irq_o(irq_o), .stat_i(word_flat)
);

// File: tb/sim_dbell_mbox.sv
module sim_dbell_mbox;
   logic        pclk = 1'b0;
   logic        presetn = 1'b0;
   logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
   logic [11:0] paddr = '0;
   logic [31:0] pwdata = '0;
   logic [2:0]  pprot = '0;
   logic [31:0] prdata;
   logic        pready, pslverr;
   logic [2:0]  irq_o;

   int checks = 0;
   int errs   = 0;
   bit done   = 1'b0;

   always #5 pclk = ~pclk;

   dbell_mbox u0 (
      .pclk(pclk), .presetn(presetn), .psel(psel), .penable(penable), .pwrite(pwrite),
      .paddr(paddr), .pwdata(pwdata), .pprot(pprot), .prdata(prdata), .pready(pready),
      .pslverr(pslverr), .irq_o(irq_o)
   );

   typedef struct packed {
      logic        wr;
      logic [11:0] a;
      logic [31:0] d;
      logic        ns;
      logic [31:0] exp;
      logic        experr;
      logic [3:0]  req;
   } vec_t;

   localparam int NV = 20;
   localparam vec_t TBL [NV] = '{
      '{1'b1, 12'h008, 32'h0000_00F1, 1'b1, 32'h0,         1'b0, 4'd2}, // R2 R8
      '{1'b0, 12'h000, 32'h0,         1'b1, 32'h0000_00F1, 1'b0, 4'd2}, // R2 R8
      '{1'b1, 12'h010, 32'h0000_0011, 1'b1, 32'h0,         1'b0, 4'd3}, // R3
      '{1'b0, 12'h000, 32'h0,         1'b0, 32'h0000_00E0, 1'b0, 4'd3}, // R3
      '{1'b1, 12'h028, 32'h8000_0001, 1'b0, 32'h0,         1'b0, 4'd6}, // R6
      '{1'b0, 12'h020, 32'h0,         1'b1, 32'h8000_0001, 1'b0, 4'd6}, // R6
      '{1'b0, 12'h000, 32'h0,         1'b0, 32'h0000_00E0, 1'b0, 4'd6}, // R6
      '{1'b1, 12'h208, 32'h0000_FF00, 1'b1, 32'h0,         1'b1, 4'd7}, // R7
      '{1'b0, 12'h200, 32'h0,         1'b0, 32'h0,         1'b0, 4'd7}, // R7
      '{1'b1, 12'h208, 32'h0000_FF00, 1'b0, 32'h0,         1'b0, 4'd7}, // R7
      '{1'b0, 12'h200, 32'h0,         1'b1, 32'h0,         1'b1, 4'd7}, // R7
      '{1'b0, 12'h200, 32'h0,         1'b0, 32'h0000_FF00, 1'b0, 4'd7}, // R7
      '{1'b1, 12'h000, 32'hFFFF_FFFF, 1'b0, 32'h0,         1'b0, 4'd4}, // R4
      '{1'b0, 12'h000, 32'h0,         1'b0, 32'h0000_00E0, 1'b0, 4'd4}, // R4
      '{1'b0, 12'h008, 32'h0,         1'b0, 32'h0,         1'b0, 4'd4}, // R4
      '{1'b1, 12'h100, 32'h0000_FFFF, 1'b0, 32'h0,         1'b0, 4'd9}, // R9
      '{1'b0, 12'h100, 32'h0,         1'b0, 32'h0,         1'b0, 4'd9}, // R9
      '{1'b0, 12'h004, 32'h0,         1'b0, 32'h0,         1'b0, 4'd9}, // R9
      '{1'b1, 12'h210, 32'hFFFF_FFFF, 1'b1, 32'h0,         1'b1, 4'd7}, // R7
      '{1'b0, 12'h200, 32'h0,         1'b0, 32'h0000_FF00, 1'b0, 4'd7}  // R7
   };

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errs++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic apb(input bit wr, input logic [11:0] a, input logic [31:0] d, input bit ns,
                      output logic [31:0] rd, output logic err, output logic rdy);
      @(negedge pclk);
      psel = 1'b1; penable = 1'b0; pwrite = wr; paddr = a; pwdata = d;
      pprot = {1'b0, ns, 1'b0};
      @(negedge pclk);
      penable = 1'b1;
      #1;
      rd = prdata; err = pslverr; rdy = pready;
      @(negedge pclk);
      psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
   endtask

   initial begin
      repeat (20000) @(posedge pclk);
      if (!done) begin
         checks++; errs++;
         $display("FAIL watchdog expired");
         $display("Result: errors=%0d of %0d checks", errs, checks);
         $finish;
      end
   end

   initial begin
      logic [31:0] rd;
      logic        err, rdy;

      // R1: reset state
      repeat (2) @(negedge pclk);
      chk("R1 irq in reset", {29'd0, irq_o}, 32'h0);
      presetn = 1'b1;
      apb(1'b0, 12'h000, 32'h0, 1'b0, rd, err, rdy); chk("R1 ch0 after reset", rd, 32'h0);
      apb(1'b0, 12'h020, 32'h0, 1'b0, rd, err, rdy); chk("R1 ch1 after reset", rd, 32'h0);
      apb(1'b0, 12'h200, 32'h0, 1'b0, rd, err, rdy); chk("R1 ch2 after reset", rd, 32'h0);

      // table walk
      for (int k = 0; k < NV; k++) begin
         apb(TBL[k].wr, TBL[k].a, TBL[k].d, TBL[k].ns, rd, err, rdy);
         chk("R10 pready", {31'd0, rdy}, 32'h1);
         chk($sformatf("R%0d pslverr row %0d", TBL[k].req, k), {31'd0, err}, {31'd0, TBL[k].experr});
         if (!TBL[k].wr)
            chk($sformatf("R%0d prdata row %0d", TBL[k].req, k), rd, TBL[k].exp);
      end

      // R5: interrupt latency on clear then set of channel 0
      apb(1'b1, 12'h010, 32'hFFFF_FFFF, 1'b1, rd, err, rdy);
      chk("R5 irq0 still high at write edge", {31'd0, irq_o[0]}, 32'h1);
      @(negedge pclk);
      chk("R5 irq0 low one cycle later", {31'd0, irq_o[0]}, 32'h0);
      apb(1'b1, 12'h008, 32'h0000_0020, 1'b1, rd, err, rdy);
      chk("R5 irq0 still low at write edge", {31'd0, irq_o[0]}, 32'h0);
      @(negedge pclk);
      chk("R5 irq0 high one cycle later", {31'd0, irq_o[0]}, 32'h1);
      chk("R6 irq1 and irq2 untouched", {30'd0, irq_o[2:1]}, 32'h3);

      // R11: no self-clear over idle cycles
      repeat (40) @(negedge pclk);
      apb(1'b0, 12'h000, 32'h0, 1'b0, rd, err, rdy);
      chk("R11 ch0 holds", rd, 32'h0000_0020);
      chk("R11 irq holds", {29'd0, irq_o}, 32'h7);

      // R1: reset in mid-run
      @(negedge pclk);
      presetn = 1'b0;
      #1;
      chk("R1 irq cleared by reset", {29'd0, irq_o}, 32'h0);
      @(negedge pclk);
      presetn = 1'b1;
      apb(1'b0, 12'h200, 32'h0, 1'b0, rd, err, rdy); chk("R1 ch2 cleared", rd, 32'h0);
      apb(1'b0, 12'h020, 32'h0, 1'b0, rd, err, rdy); chk("R1 ch1 cleared", rd, 32'h0);

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end
endmodule